// File: doc/BRIEF.md
# Interrupt Request Level Sampler

This block sits in front of a CPU exception sequencer. It takes a three-bit, active-low interrupt request level that arrives asynchronously from an external interrupt controller and passes it through a two-stage synchronizer into the CPU clock domain. At the one cycle per instruction that the sequencer marks with a sample strobe, it decides whether an interrupt is to be taken. In that same cycle it captures the request level into an interrupt level latch. The acknowledge cycle and the vector selection use only that latched value.

Levels 1 to 6 are level-sensitive and maskable. Only the level present at the strobe counts, and it must exceed the three-bit mask from the status register. Level 7 cannot be masked and is recognised on its edge. A fresh entry into level 7 arms a pending flag. That flag wins at the next strobe even with the mask at 7. It is cleared when the level-7 interrupt is acknowledged. Choosing between several sources is left to the external controller. The block sees only the single level now present on the pins.

Top module: `irq_level_sampler`

## Requirements
- R1: After synchronous reset, `take_irq` is 0 and `irq_lvl` is 0. The level-7 pending state is cleared.
- R2: The request level is the bitwise inverse of `ipl_n`, so all-ones on `ipl_n` means level 0, which is no request. The level is seen by the decision two clocks late. A pin value set up before clock edge k is first used by a strobe sampled at edge k+2.
- R3: At a strobe, a synchronized level L in 1..6 is taken only when L > `sr_mask`. When it is taken, `take_irq` rises and `irq_lvl` equals L after that edge.
- R4: A strobe with no qualifying request leaves `take_irq` at 0 and `irq_lvl` unchanged.
- R5: Levels 1 to 6 have no memory. A request that goes away before the strobe leaves no trace.
- R6: A transition of the synchronized level into 7 arms a pending request. The next accepted strobe takes it with `irq_lvl` = 7, whatever the mask. A level held at 7 after it has been acknowledged produces no further request. The level must leave 7 and come back to arm a new one.
- R7: A pending level-7 request is taken in preference to the level-1..6 level present at the same strobe.
- R8: While `take_irq` is 1, strobes are ignored and `irq_lvl` holds, whatever the pins do.
- R9: `ack` clears `take_irq` at the next edge. `ack` takes priority over a strobe in the same cycle.
- R10: Without a strobe, `take_irq` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ipl_n | input | 3 | Asynchronous active-low interrupt request level |
| sr_mask | input | 3 | Interrupt mask from the status register |
| sample_stb | input | 1 | One-cycle decision and latch strobe from the sequencer |
| ack | input | 1 | Interrupt acknowledged; clears the taken state |
| take_irq | output | 1 | Interrupt taken and awaiting acknowledge |
| irq_lvl | output | 3 | Latched level for the acknowledge cycle and vector selection |

## Verification
The bench goes after the exact synchronizer latency. A design with one stage too few or too many would take or miss a request one strobe early or late. It checks the strict mask comparison: a design using greater-or-equal would take a level equal to the mask. It also checks a request that disappears before the strobe, which a design that latched requests would still take. Level 7 is driven held, re-entered and mixed with lower levels. A design that treated it as level-sensitive would take it repeatedly after acknowledge, and one without priority for the pending edge would report the lower level.

// File: rtl/irq_sample_pkg.sv
`timescale 1ns/1ps
package irq_sample_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = '0;
  localparam lvl_t LVL_NMI  = '1;
endpackage

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync
  import irq_sample_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  lvl_t pins_n,
  output lvl_t lvl
);
  localparam int LAST = STAGES - 1;

  lvl_t stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '1;
          else     stg[g] <= pins_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '1;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  // active-low pins: inverse gives the request level
  assign lvl = ~stg[LAST];
endmodule

// File: rtl/irq_nmi_detect.sv
`timescale 1ns/1ps
module irq_nmi_detect
  import irq_sample_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t lvl,
  input  logic clr,
  output logic pend
);
  logic at_nmi;
  logic was_nmi;
  logic enter_nmi;

  assign at_nmi    = (lvl == LVL_NMI);
  assign enter_nmi = at_nmi && !was_nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_nmi <= 1'b0;
      pend    <= 1'b0;
    end else begin
      was_nmi <= at_nmi;
      if (enter_nmi)  pend <= 1'b1;
      else if (clr)   pend <= 1'b0;
    end
  end

  // R6
  nmi_pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pend && !clr |=> pend);
  // R6
  nmi_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !pend && !at_nmi |=> !pend);
endmodule

// File: rtl/irq_decide.sv
`timescale 1ns/1ps
module irq_decide
  import irq_sample_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_t lvl,
  input  lvl_t mask,
  input  logic nmi_pend,
  input  logic stb,
  input  logic ack,
  output logic take,
  output lvl_t irq_lvl,
  output logic nmi_clr
);
  logic maskable_hit;
  logic accept;
  lvl_t pick;

  assign maskable_hit = (lvl != LVL_NMI) && (lvl > mask);
  assign accept       = stb && !take && !ack && (nmi_pend || maskable_hit);
  assign pick         = nmi_pend ? LVL_NMI : lvl;
  assign nmi_clr      = ack && take && (irq_lvl == LVL_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      take    <= 1'b0;
      irq_lvl <= LVL_NONE;
    end else if (ack) begin
      take    <= 1'b0;
    end else if (accept) begin
      take    <= 1'b1;
      irq_lvl <= pick;
    end
  end

  // R8
  take_hold_chk: assert property (@(posedge clk) disable iff (rst)
    take && !ack |=> take && $stable(irq_lvl));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !take);
  // R10
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !take && !stb |=> !take);
  // R3
  mask_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(take) && irq_lvl != LVL_NMI |-> irq_lvl > $past(mask));
  // R4
  lvl_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> irq_lvl != LVL_NONE);
endmodule

// File: rtl/irq_level_sampler.sv
`timescale 1ns/1ps
module irq_level_sampler
  import irq_sample_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] ipl_n,
  input  logic [LVL_W-1:0] sr_mask,
  input  logic             sample_stb,
  input  logic             ack,
  output logic             take_irq,
  output logic [LVL_W-1:0] irq_lvl
);
  lvl_t sync_lvl;
  logic nmi_pend;
  logic nmi_clr;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pins_n (ipl_n),
    .lvl    (sync_lvl)
  );

  irq_nmi_detect u_nmi (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sync_lvl),
    .clr  (nmi_clr),
    .pend (nmi_pend)
  );

  irq_decide u_dec (
    .clk      (clk),
    .rst      (rst),
    .lvl      (sync_lvl),
    .mask     (sr_mask),
    .nmi_pend (nmi_pend),
    .stb      (sample_stb),
    .ack      (ack),
    .take     (take_irq),
    .irq_lvl  (irq_lvl),
    .nmi_clr  (nmi_clr)
  );
endmodule

// File: tb/irq_level_sampler_bench.sv
`timescale 1ns/1ps
module irq_level_sampler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ipl_n = 3'b111;
  logic [2:0] sr_mask = 3'd7;
  logic       sample_stb = 1'b0;
  logic       ack = 1'b0;
  logic       take_irq;
  logic [2:0] irq_lvl;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  string tag = "R1";

  // model state, derived from the requirements
  logic [2:0] m_s1, m_s2;
  logic       m_prev7, m_pend, m_take;
  logic [2:0] m_lvl;

  always #2 clk = ~clk;

  irq_level_sampler u_irq_level_sampler (
    .clk(clk), .rst(rst), .ipl_n(ipl_n), .sr_mask(sr_mask),
    .sample_stb(sample_stb), .ack(ack), .take_irq(take_irq), .irq_lvl(irq_lvl)
  );

  task automatic model_reset();
    m_s1 = 3'b111; m_s2 = 3'b111; m_prev7 = 0; m_pend = 0; m_take = 0; m_lvl = 0;
  endtask

  task automatic model_step(input logic [2:0] pins_n, input logic [2:0] msk,
                            input logic stb, input logic ak);
    logic [2:0] now_lvl;
    logic at7, rise, clr, n_pend, n_take;
    logic [2:0] n_lvl;
    now_lvl = ~m_s2;                         // R2: two-stage lag, active low
    at7 = (now_lvl == 3'd7);
    rise = at7 && !m_prev7;
    clr = ak && m_take && (m_lvl == 3'd7);
    n_pend = rise ? 1'b1 : (clr ? 1'b0 : m_pend);
    n_take = m_take; n_lvl = m_lvl;
    if (ak) n_take = 1'b0;                   // R9
    else if (stb && !m_take) begin
      if (m_pend) begin n_take = 1'b1; n_lvl = 3'd7; end          // R6 R7
      else if (now_lvl != 3'd7 && now_lvl > msk) begin           // R3
        n_take = 1'b1; n_lvl = now_lvl;
      end
    end
    m_s2 = m_s1; m_s1 = pins_n; m_prev7 = at7;
    m_pend = n_pend; m_take = n_take; m_lvl = n_lvl;
  endtask

  task automatic compare();
    vectors++;
    if (take_irq !== m_take || irq_lvl !== m_lvl) begin
      misses++;
      $display("FAIL %s: take=%0b lvl=%0d expected take=%0b lvl=%0d",
               tag, take_irq, irq_lvl, m_take, m_lvl);
    end
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(input logic [2:0] level, input logic [2:0] msk,
                     input logic stb, input logic ak);
    ipl_n = ~level; sr_mask = msk; sample_stb = stb; ack = ak;
    model_step(~level, msk, stb, ak);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 3'd7, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20181027));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tag = "R1 reset state";
    compare();
    idle(3);

    tag = "R2 sync latency";
    cyc(3'd5, 3'd0, 1'b0, 1'b0);
    cyc(3'd5, 3'd0, 1'b1, 1'b0);   // too early: old level
    cyc(3'd5, 3'd0, 1'b1, 1'b0);   // now taken as level 5
    cyc(3'd0, 3'd0, 1'b0, 1'b1);
    idle(3);

    tag = "R3 mask compare";
    cyc(3'd3, 3'd3, 1'b0, 1'b0); cyc(3'd3, 3'd3, 1'b0, 1'b0);
    cyc(3'd3, 3'd3, 1'b1, 1'b0);   // equal to mask: not taken
    cyc(3'd3, 3'd2, 1'b1, 1'b0);   // above mask: taken as 3
    cyc(3'd3, 3'd2, 1'b0, 1'b1);
    cyc(3'd6, 3'd5, 1'b0, 1'b0); cyc(3'd6, 3'd5, 1'b0, 1'b0);
    cyc(3'd6, 3'd5, 1'b1, 1'b0);
    cyc(3'd0, 3'd5, 1'b0, 1'b1);
    idle(3);

    tag = "R4 no request";
    for (int i = 0; i < 4; i++) cyc(3'd0, 3'd0, 1'b1, 1'b0);
    cyc(3'd1, 3'd1, 1'b0, 1'b0); cyc(3'd1, 3'd1, 1'b0, 1'b0);
    cyc(3'd1, 3'd1, 1'b1, 1'b0);

    tag = "R5 transient request";
    cyc(3'd4, 3'd0, 1'b0, 1'b0); cyc(3'd4, 3'd0, 1'b0, 1'b0);
    idle(3);
    cyc(3'd0, 3'd0, 1'b1, 1'b0);

    tag = "R6 level 7 edge";
    cyc(3'd7, 3'd7, 1'b0, 1'b0); cyc(3'd7, 3'd7, 1'b0, 1'b0);
    cyc(3'd7, 3'd7, 1'b0, 1'b0);
    cyc(3'd7, 3'd7, 1'b1, 1'b0);   // taken despite mask 7
    cyc(3'd7, 3'd7, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cyc(3'd7, 3'd0, 1'b1, 1'b0); // held: no retake
    cyc(3'd2, 3'd7, 1'b0, 1'b0); cyc(3'd2, 3'd7, 1'b0, 1'b0);
    cyc(3'd7, 3'd7, 1'b0, 1'b0); cyc(3'd7, 3'd7, 1'b0, 1'b0);
    cyc(3'd7, 3'd7, 1'b0, 1'b0);
    cyc(3'd7, 3'd7, 1'b1, 1'b0);   // re-entry: new request
    cyc(3'd0, 3'd7, 1'b0, 1'b1);
    idle(3);

    tag = "R7 level 7 priority";
    cyc(3'd7, 3'd0, 1'b0, 1'b0); cyc(3'd7, 3'd0, 1'b0, 1'b0);
    cyc(3'd6, 3'd0, 1'b0, 1'b0); cyc(3'd6, 3'd0, 1'b0, 1'b0);
    cyc(3'd6, 3'd0, 1'b0, 1'b0);
    cyc(3'd6, 3'd0, 1'b1, 1'b0);   // pending 7 wins over 6
    cyc(3'd6, 3'd0, 1'b0, 1'b1);
    cyc(3'd6, 3'd0, 1'b1, 1'b0);   // then 6 is taken
    cyc(3'd0, 3'd0, 1'b0, 1'b1);
    idle(3);

    tag = "R8 latch holds";
    cyc(3'd2, 3'd0, 1'b0, 1'b0); cyc(3'd2, 3'd0, 1'b0, 1'b0);
    cyc(3'd2, 3'd0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc(3'd6, 3'd0, 1'b1, 1'b0);

    tag = "R9 ack priority";
    cyc(3'd6, 3'd0, 1'b1, 1'b1);   // ack wins over strobe
    cyc(3'd6, 3'd0, 1'b1, 1'b0);   // now strobe takes 6
    cyc(3'd0, 3'd0, 1'b0, 1'b1);
    idle(3);

    tag = "R10 no strobe";
    for (int i = 0; i < 8; i++) cyc(3'd5, 3'd0, 1'b0, 1'b0);
    cyc(3'd0, 3'd0, 1'b0, 1'b0);
    idle(3);

    tag = "R3 R5 R6 random mix";
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] lv;
      lv = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom % 8);
      cyc(lv, 3'($urandom % 8), ($urandom % 4 == 0),
          m_take && ($urandom % 3 == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule